// File: doc/BRIEF.md
# Charge Phase Sequencer

This block runs a single charging cycle of a synchronous buck power stage each time a controller above it raises a charge request. It switches the high-side gate on, waits for the gate-threshold acknowledge and for a cleaned over-current event, then switches the high-side gate off. Only after the high-side acknowledge reports that the transistor is really off does it switch the low-side gate on. It then waits for a cleaned zero-crossing event, switches the low-side gate off, and completes the request with its own acknowledge.

The two comparator events are never read raw. Each one comes from an external sanitiser that the block arms with a control line and that answers on a clean line. The sequencer raises a control line when it needs the matching event. It lowers that line, so that the sanitiser resets, in the same cycle as the gate transition that follows the event. It does not acknowledge the charge request until both clean lines have fallen again.

All five inputs may come from asynchronous logic. Each one passes through a flip-flop synchroniser of `SYNC_STAGES` stages before the sequencer state machine uses it. Every output is a register.

Top module: `chrg_phase_seq`

## Requirements
- R1: While reset is asserted, and afterwards as long as no request arrives, all five outputs (`chg_ack`, `hs_gate`, `ls_gate`, `oc_arm`, `zc_arm`) are low.
- R2: A rising `chg_req` makes `hs_gate` and `oc_arm` rise in the same cycle, with every other output low. As the vector {chg_ack,hs_gate,ls_gate,oc_arm,zc_arm} this is 5'b01010.
- R3: `hs_gate` stays high until `hs_done` and `oc_seen` have both been seen high. `hs_gate` and `oc_arm` then fall together (vector 5'b00000), and it does not matter which of the two inputs arrived first.
- R4: `ls_gate` and `zc_arm` rise together (vector 5'b00101), and only after `hs_done` has been seen low.
- R5: `ls_gate` stays high until `ls_done` and `zc_seen` have both been seen high. `ls_gate` and `zc_arm` then fall together (vector 5'b00000).
- R6: `chg_ack` rises (vector 5'b10000) only once `ls_done`, `oc_seen` and `zc_seen` are all low. It falls only after `chg_req` has been seen low. A new cycle starts only after that.
- R7: A clean line or a gate acknowledge that changes while the matching control or gate output is low changes no output. This covers pulses while idle and a zero-crossing pulse during the high-side phase.
- R8: `hs_gate` and `ls_gate` are never high in the same cycle.
- R9: `oc_arm` and `zc_arm` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chg_req | input | 1 | Charge request (passive handshake) |
| chg_ack | output | 1 | Charge acknowledge |
| hs_gate | output | 1 | High-side gate command |
| hs_done | input | 1 | High-side gate threshold acknowledge |
| ls_gate | output | 1 | Low-side gate command |
| ls_done | input | 1 | Low-side gate threshold acknowledge |
| oc_arm | output | 1 | Over-current sanitiser control |
| oc_seen | input | 1 | Over-current sanitiser clean output |
| zc_arm | output | 1 | Zero-crossing sanitiser control |
| zc_seen | input | 1 | Zero-crossing sanitiser clean output |

## Verification
The hardest situation to reach from the ports is the one where the off-critical-path sanitiser reset has not finished: the over-current clean line is still high after the low-side phase is already complete, so the acknowledge has to wait for it. The stimulus holds `oc_seen` high for many cycles after `oc_arm` falls. It also delays the high-side acknowledge fall, and in other runs it presents the over-current event before the gate acknowledge or injects a zero-crossing pulse during the high-side phase. The scoreboard expects one exact order of output vectors, so any early, extra or missing transition shows up as a mismatch.

// File: rtl/chrg_seq_pkg.sv
package chrg_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HI_ON,
        PH_HI_OFF,
        PH_LO_ON,
        PH_LO_OFF,
        PH_DONE
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   hs;
        logic   ls;
        logic   oc_arm;
        logic   zc_arm;
        logic   ack;
    } seq_regs_t;

    localparam int unsigned N_INPUTS = 5;
    localparam int unsigned IDX_REQ  = 0;
    localparam int unsigned IDX_HSD  = 1;
    localparam int unsigned IDX_LSD  = 2;
    localparam int unsigned IDX_OC   = 3;
    localparam int unsigned IDX_ZC   = 4;

endpackage

// File: rtl/chrg_sync_bank.sv
module chrg_sync_bank #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[LAST];

endmodule

// File: rtl/chrg_phase_fsm.sv
module chrg_phase_fsm
    import chrg_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic hs_ack_s,
    input  logic ls_ack_s,
    input  logic oc_s,
    input  logic zc_s,
    output logic hs_gate,
    output logic ls_gate,
    output logic oc_arm,
    output logic zc_arm,
    output logic ack
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (req_s) begin
                    r_d.phase  = PH_HI_ON;
                    r_d.hs     = 1'b1;
                    r_d.oc_arm = 1'b1;
                end
            end
            PH_HI_ON: begin
                if (hs_ack_s && oc_s) begin
                    r_d.phase  = PH_HI_OFF;
                    r_d.hs     = 1'b0;
                    r_d.oc_arm = 1'b0;
                end
            end
            PH_HI_OFF: begin
                if (!hs_ack_s) begin
                    r_d.phase  = PH_LO_ON;
                    r_d.ls     = 1'b1;
                    r_d.zc_arm = 1'b1;
                end
            end
            PH_LO_ON: begin
                if (ls_ack_s && zc_s) begin
                    r_d.phase  = PH_LO_OFF;
                    r_d.ls     = 1'b0;
                    r_d.zc_arm = 1'b0;
                end
            end
            PH_LO_OFF: begin
                if (!ls_ack_s && !zc_s && !oc_s) begin
                    r_d.phase = PH_DONE;
                    r_d.ack   = 1'b1;
                end
            end
            PH_DONE: begin
                if (!req_s) begin
                    r_d.phase = PH_IDLE;
                    r_d.ack   = 1'b0;
                end
            end
            default: begin
                r_d = '{phase: PH_IDLE, default: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_gate = r_q.hs;
    assign ls_gate = r_q.ls;
    assign oc_arm  = r_q.oc_arm;
    assign zc_arm  = r_q.zc_arm;
    assign ack     = r_q.ack;

    // R8
    no_gate_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R9
    arm_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({oc_arm, zc_arm}));

    // R3
    hs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_gate) |-> ($past(hs_ack_s && oc_s) && !oc_arm));

    // R4
    ls_after_hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ($past(!hs_ack_s) && zc_arm));

    // R5
    ls_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ls_gate) |-> $past(ls_ack_s && zc_s));

    // R6
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> ($past(!ls_ack_s && !zc_s && !oc_s) && !hs_gate && !ls_gate));

    // R6
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $past(!req_s));

    // R2
    hs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> (oc_arm && $past(req_s) && !ack));

endmodule

// File: rtl/chrg_phase_seq.sv
module chrg_phase_seq
    import chrg_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_req,
    output logic chg_ack,
    output logic hs_gate,
    input  logic hs_done,
    output logic ls_gate,
    input  logic ls_done,
    output logic oc_arm,
    input  logic oc_seen,
    output logic zc_arm,
    input  logic zc_seen
);
    logic [N_INPUTS-1:0] raw_in, syn_in;

    always_comb begin
        raw_in          = '0;
        raw_in[IDX_REQ] = chg_req;
        raw_in[IDX_HSD] = hs_done;
        raw_in[IDX_LSD] = ls_done;
        raw_in[IDX_OC]  = oc_seen;
        raw_in[IDX_ZC]  = zc_seen;
    end

    chrg_sync_bank #(
        .WIDTH  (N_INPUTS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (syn_in)
    );

    chrg_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_s    (syn_in[IDX_REQ]),
        .hs_ack_s (syn_in[IDX_HSD]),
        .ls_ack_s (syn_in[IDX_LSD]),
        .oc_s     (syn_in[IDX_OC]),
        .zc_s     (syn_in[IDX_ZC]),
        .hs_gate  (hs_gate),
        .ls_gate  (ls_gate),
        .oc_arm   (oc_arm),
        .zc_arm   (zc_arm),
        .ack      (chg_ack)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_ack && !hs_gate && !ls_gate && $past(!syn_in[IDX_REQ]) && $stable(chg_ack) && $stable(hs_gate))
        |=> !ls_gate);

endmodule

// File: tb/sim_chrg_phase_seq.sv
module sim_chrg_phase_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chg_req = 1'b0, hs_done = 1'b0, ls_done = 1'b0, oc_seen = 1'b0, zc_seen = 1'b0;
    logic chg_ack, hs_gate, ls_gate, oc_arm, zc_arm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;
    logic [4:0] exp_q[$];
    logic [4:0] prev_v;

    always #10 clk = ~clk;

    chrg_phase_seq u0 (
        .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .chg_ack(chg_ack),
        .hs_gate(hs_gate), .hs_done(hs_done), .ls_gate(ls_gate), .ls_done(ls_done),
        .oc_arm(oc_arm), .oc_seen(oc_seen), .zc_arm(zc_arm), .zc_seen(zc_seen)
    );

    wire [4:0] vec = {chg_ack, hs_gate, ls_gate, oc_arm, zc_arm};

    task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected vector for every change of the output vector
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (hs_gate && ls_gate) check(1'b0, "R8 gate overlap", vec, 5'b0);
                if (oc_arm && zc_arm) check(1'b0, "R9 arm overlap", vec, 5'b0);
                if (vec !== prev_v) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7 unexpected output change", vec, prev_v);
                    end else begin
                        logic [4:0] e;
                        e = exp_q.pop_front();
                        check(vec === e, "R2-R6 sequence", vec, e);
                    end
                    prev_v = vec;
                end
            end
        end
    end

    task automatic run_cycle(input int hs_on_dly, input int hs_off_dly, input int oc_hold,
                             input bit oc_first, input bit zc_spur, input int zc_hold);
        exp_q.push_back(5'b01010); // R2
        exp_q.push_back(5'b00000); // R3
        exp_q.push_back(5'b00101); // R4
        exp_q.push_back(5'b00000); // R5
        exp_q.push_back(5'b10000); // R6
        exp_q.push_back(5'b00000); // R6
        @(negedge clk); chg_req = 1'b1;
        wait (hs_gate === 1'b1);
        @(negedge clk);
        if (oc_first) begin wait_neg(4); oc_seen = 1'b1; end
        if (zc_spur) begin wait_neg(2); zc_seen = 1'b1; wait_neg(3); zc_seen = 1'b0; end
        wait_neg(hs_on_dly); hs_done = 1'b1;
        wait_neg(3); oc_seen = 1'b1;
        wait (hs_gate === 1'b0);
        @(negedge clk);
        fork
            begin wait_neg(hs_off_dly); hs_done = 1'b0; end
            begin wait_neg(oc_hold); oc_seen = 1'b0; end
        join_none
        wait (ls_gate === 1'b1);
        // R4: low side only after high-side acknowledge fell
        check(hs_done === 1'b0, "R4 ls_gate with hs_done high", {4'b0, hs_done}, 5'b0);
        @(negedge clk);
        wait_neg(3); ls_done = 1'b1;
        wait_neg(2); zc_seen = 1'b1;
        wait (ls_gate === 1'b0);
        @(negedge clk);
        fork
            begin wait_neg(2); ls_done = 1'b0; end
            begin wait_neg(zc_hold); zc_seen = 1'b0; end
        join_none
        wait (chg_ack === 1'b1);
        // R6: acknowledge only after all clean lines and the low-side ack fell
        check({oc_seen, zc_seen, ls_done} === 3'b000, "R6 ack before clean lines low",
              {2'b0, oc_seen, zc_seen, ls_done}, 5'b0);
        wait_neg(4); chg_req = 1'b0;
        wait (chg_ack === 1'b0);
        wait_neg(5);
    endtask

    initial begin
        prev_v = 5'b0;
        wait_neg(2);
        check(vec === 5'b0, "R1 reset state", vec, 5'b0);
        wait_neg(2);
        rst_n = 1'b1;
        mon_en = 1'b1;
        wait_neg(5);
        check(vec === 5'b0, "R1 idle after reset", vec, 5'b0);

        // R7: pulses on clean lines and acknowledges while idle
        oc_seen = 1'b1; zc_seen = 1'b1; wait_neg(4);
        oc_seen = 1'b0; zc_seen = 1'b0; hs_done = 1'b1; ls_done = 1'b1; wait_neg(4);
        hs_done = 1'b0; ls_done = 1'b0; wait_neg(6);
        check(vec === 5'b0, "R7 idle pulses ignored", vec, 5'b0);

        run_cycle(3, 2, 2, 1'b0, 1'b0, 2);     // plain cycle
        run_cycle(10, 15, 3, 1'b0, 1'b0, 3);   // slow high-side release, R4
        run_cycle(2, 2, 2, 1'b1, 1'b0, 2);     // over-current before gate ack, R3
        run_cycle(5, 3, 2, 1'b0, 1'b1, 4);     // zero-crossing pulse in high phase, R7
        run_cycle(2, 2, 60, 1'b0, 1'b0, 2);    // late over-current clean fall, R6
        run_cycle(2, 2, 2, 1'b0, 1'b0, 40);    // late zero-crossing clean fall, R6
        run_cycle(1, 1, 1, 1'b0, 1'b0, 1);     // back-to-back fast

        wait_neg(10);
        check(exp_q.size() == 0, "R2-R6 missing transitions", 5'(exp_q.size()), 5'b0);
        check(vec === 5'b0, "R1 idle at end", vec, 5'b0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (R1-R9 run hung) actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule